// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers eight independent reset requests into a single system reset output. The requests are power-on, brown-out, the external active-low master-clear pin, a software reset instruction, watchdog timeout, trap conflict, illegal opcode or uninitialized working register access, and configuration mismatch. Any one active request drives the reset output high at once. Once the last request goes away, the output is held for a fixed number of clock edges, so it always deasserts on the clock. The master-clear pin is glitch filtered: a low level must persist for several consecutive clock samples before it counts as a request.

Each reset cause sets its own bit in a 16-bit cause register, and software reads that register on a status output. Bits stay set through every reset except power-on, so software clears them after reading them. A write port lets software set or clear any implemented bit. A write only changes status and never starts a reset. Power-on acts as the block's asynchronous reset. It forces the cause register to show only the power-on bit.

Top module: `rstctl_top`

## Requirements
- R1: `sys_rst` is high in any cycle where `por_req`, `bor_req`, `swr_req`, `wdt_req`, `trap_req`, `iop_req` or `cfg_req` is high, or where the filtered master-clear request is active.
- R2: The filtered master-clear request becomes active only after `mclr_pin_n` has been sampled low on 4 consecutive rising edges. It stays active while the pin stays low. A low pulse of 3 or fewer samples causes neither a reset nor status bit 7.
- R3: After the last active source is released, `sys_rst` stays high for 16 more rising edges and then falls.
- R4: Cause bit positions: bit 0 power-on, bit 1 brown-out, bit 2 illegal opcode/uninitialized register, bit 3 configuration mismatch, bit 4 watchdog, bit 6 software reset, bit 7 master-clear, bit 15 trap conflict. A source sets its bit on every rising edge at which it is active.
- R5: While `por_req` is high, `status` reads 16'h0001, whatever it held before.
- R6: Non-power-on resets never clear cause bits. Bits from successive causes accumulate.
- R7: A write (`wr_en` high at a rising edge) loads `wr_data & 16'h80DF`. Unimplemented bits always read zero.
- R8: A write on its own never raises `sys_rst`.
- R9: When a source sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: If brown-out is still active in the first cycle after power-on is released, `status` reads 16'h0003.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, active high, asynchronous block reset |
| bor_req | input | 1 | Brown-out request |
| mclr_pin_n | input | 1 | External master-clear pin, active low, synchronous to `clk` |
| swr_req | input | 1 | Software reset instruction request |
| wdt_req | input | 1 | Watchdog timeout request |
| trap_req | input | 1 | Trap conflict request |
| iop_req | input | 1 | Illegal opcode / uninitialized register request |
| cfg_req | input | 1 | Configuration mismatch request |
| wr_en | input | 1 | Cause register write strobe |
| wr_data | input | 16 | Cause register write value |
| sys_rst | output | 1 | System reset, active high |
| status | output | 16 | Cause register value |

## Verification
The bench builds the block with its defaults: a filter length of 4 and a stretch length of 16. These short windows let directed cases place pin pulses exactly one sample short of and exactly at the filter length, and let the bench watch every step of the stretch countdown. Random mixes of request pulses, pin activity and writes then bring overlapping stretches and write/set collisions, which a cycle model in the bench predicts.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int CAUSE_W = 16;

  // request vector; field order is only internal
  typedef struct packed {
    logic trap;
    logic mclr;
    logic swr;
    logic wdt;
    logic cfg;
    logic iop;
    logic bor;
    logic por;
  } rst_src_t;

  // place each request on its cause bit
  function automatic logic [CAUSE_W-1:0] cause_bits(input rst_src_t s);
    logic [CAUSE_W-1:0] m;
    m     = '0;
    m[0]  = s.por;
    m[1]  = s.bor;
    m[2]  = s.iop;
    m[3]  = s.cfg;
    m[4]  = s.wdt;
    m[6]  = s.swr;
    m[7]  = s.mclr;
    m[15] = s.trap;
    return m;
  endfunction

  function automatic logic [CAUSE_W-1:0] impl_mask();
    return cause_bits('1);
  endfunction

  function automatic logic [CAUSE_W-1:0] por_value();
    rst_src_t s;
    s     = '0;
    s.por = 1'b1;
    return cause_bits(s);
  endfunction

endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic req_act
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      low_cnt_q <= '0;
    else if (pin_n)
      low_cnt_q <= '0;
    else if (low_cnt_q != LIMIT)
      low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign req_act = (low_cnt_q == LIMIT);

  AST_FILT_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    req_act |-> !$past(pin_n)); // R2
  AST_FILT_HIGH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    pin_n |=> !req_act); // R2
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int STRETCH_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic any_src,
  output logic hold
);
  localparam int CW = $clog2(STRETCH_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      cnt_q <= LOAD;
    else if (any_src)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign hold = (cnt_q != '0);

  AST_SRC_RELOADS: assert property (@(posedge clk) disable iff (rst)
    any_src |=> hold); // R3
endmodule

// File: rtl/rstctl_cause_reg.sv
module rstctl_cause_reg
  import rstctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  rst_src_t           src,
  input  logic               wr_en,
  input  logic [CAUSE_W-1:0] wr_data,
  output logic [CAUSE_W-1:0] status
);
  localparam logic [CAUSE_W-1:0] MASK    = impl_mask();
  localparam logic [CAUSE_W-1:0] POR_VAL = por_value();

  logic [CAUSE_W-1:0] hw_set;
  logic [CAUSE_W-1:0] base;
  logic [CAUSE_W-1:0] status_q;

  assign hw_set = cause_bits(src);
  assign base   = wr_en ? (wr_data & MASK) : status_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      status_q <= POR_VAL;
    else
      status_q <= base | hw_set;
  end

  assign status = status_q;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((status_q & $past(hw_set)) == $past(hw_set))); // R9
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int STRETCH_LEN = 16
) (
  input  logic        clk,
  input  logic        por_req,
  input  logic        bor_req,
  input  logic        mclr_pin_n,
  input  logic        swr_req,
  input  logic        wdt_req,
  input  logic        trap_req,
  input  logic        iop_req,
  input  logic        cfg_req,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        sys_rst,
  output logic [15:0] status
);
  logic     mclr_act;
  logic     any_src;
  logic     stretch_hold;
  rst_src_t src;

  rstctl_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(por_req), .pin_n(mclr_pin_n), .req_act(mclr_act)
  );

  always_comb begin
    src      = '0;
    src.por  = por_req;
    src.bor  = bor_req;
    src.iop  = iop_req;
    src.cfg  = cfg_req;
    src.wdt  = wdt_req;
    src.swr  = swr_req;
    src.mclr = mclr_act;
    src.trap = trap_req;
  end

  assign any_src = |src;

  rstctl_stretch #(.STRETCH_LEN(STRETCH_LEN)) u_str (
    .clk(clk), .rst(por_req), .any_src(any_src), .hold(stretch_hold)
  );

  rstctl_cause_reg u_cause (
    .clk(clk), .rst(por_req), .src(src), .wr_en(wr_en),
    .wr_data(wr_data), .status(status)
  );

  assign sys_rst = any_src | stretch_hold;

  AST_SRC_FORCES_RST: assert property (@(posedge clk) disable iff (por_req)
    any_src |-> sys_rst); // R1
  AST_PAST_SRC_HOLDS: assert property (@(posedge clk) disable iff (por_req)
    $past(any_src) |-> sys_rst); // R3
endmodule

// File: tb/tb_rstctl_top.sv
module tb_rstctl_top;
  localparam int FILT = 4;
  localparam int STR  = 16;

  logic clk = 1'b0;
  logic por_req = 1'b1, bor_req = 1'b0, mclr_pin_n = 1'b1, swr_req = 1'b0;
  logic wdt_req = 1'b0, trap_req = 1'b0, iop_req = 1'b0, cfg_req = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic sys_rst;
  logic [15:0] status;

  int n_chk = 0, n_fail = 0;
  int m_low = 0, m_cnt = STR;
  logic [15:0] m_stat = 16'h0001;
  bit done = 0;

  always #2 clk = ~clk;

  rstctl_top #(.FILT_LEN(FILT), .STRETCH_LEN(STR)) dut (
    .clk, .por_req, .bor_req, .mclr_pin_n, .swr_req, .wdt_req, .trap_req,
    .iop_req, .cfg_req, .wr_en, .wr_data, .sys_rst, .status
  );

  // cause index -> bit position (R4)
  function automatic int bitpos(input int i);
    case (i)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 4;  5: return 6;  6: return 7;  default: return 15;
    endcase
  endfunction

  function automatic logic [15:0] hw_bits(input logic [7:0] a);
    logic [15:0] r = '0;
    for (int i = 0; i < 8; i++) if (a[i]) r[bitpos(i)] = 1'b1;
    return r;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are already driven (at a falling edge); check, model the edge, advance
  task automatic tick();
    logic [7:0] a;
    logic mact;
    #1;
    if (por_req) begin m_stat = 16'h0001; m_cnt = STR; m_low = 0; end
    mact = (m_low == FILT);
    a = {trap_req, mact, swr_req, wdt_req, cfg_req, iop_req, bor_req, por_req};
    chk({15'b0, sys_rst}, {15'b0, (|a) || (m_cnt != 0)}, "R1 R3 sys_rst");
    chk(status, m_stat, "R4 R6 R7 status");
    if (!por_req) begin
      m_stat = (wr_en ? (wr_data & 16'h80DF) : m_stat) | hw_bits(a);
      m_cnt  = (|a) ? STR : ((m_cnt > 0) ? m_cnt - 1 : 0);
      m_low  = mclr_pin_n ? 0 : ((m_low < FILT) ? m_low + 1 : FILT);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    repeat (3) tick();
    chk(status, 16'h0001, "R5 power-on value");
    por_req = 1'b0;
    repeat (STR + 1) tick();
    chk({15'b0, sys_rst}, 16'h0, "R3 released after stretch");

    wr_en = 1'b1; wr_data = 16'hFFFF; tick();
    wr_en = 1'b0; tick();
    chk(status, 16'h80DF, "R7 write masked");
    chk({15'b0, sys_rst}, 16'h0, "R8 write no reset");
    wr_en = 1'b1; wr_data = 16'h0000; tick(); wr_en = 1'b0;

    for (int s = 0; s < 6; s++) begin
      case (s)
        0: bor_req = 1'b1; 1: iop_req = 1'b1; 2: cfg_req = 1'b1;
        3: wdt_req = 1'b1; 4: swr_req = 1'b1; default: trap_req = 1'b1;
      endcase
      tick();
      {bor_req, iop_req, cfg_req, wdt_req, swr_req, trap_req} = '0;
      repeat (STR + 2) tick();
    end
    chk(status, 16'h805E, "R6 R4 accumulated causes");

    mclr_pin_n = 1'b0; repeat (FILT - 1) tick();
    mclr_pin_n = 1'b1; repeat (3) tick();
    chk({15'b0, sys_rst}, 16'h0, "R2 short pulse no reset");
    chk(status & 16'h0080, 16'h0, "R2 short pulse no bit7");
    mclr_pin_n = 1'b0; repeat (FILT) tick();
    #1 chk({15'b0, sys_rst}, 16'h1, "R2 filtered pin reset");
    tick();
    mclr_pin_n = 1'b1; repeat (STR + 2) tick();
    chk(status & 16'h0080, 16'h0080, "R2 R4 bit7 set");

    wr_en = 1'b1; wr_data = 16'h0000; wdt_req = 1'b1; tick();
    wr_en = 1'b0; wdt_req = 1'b0; tick();
    chk(status, 16'h0010, "R9 hardware set wins");
    repeat (STR + 2) tick();
    for (int k = 0; k < 4; k++) begin
      wr_en = 1'b1; wr_data = 16'(k * 16'h4141); tick();
    end
    wr_en = 1'b0; tick();
    chk({15'b0, sys_rst}, 16'h0, "R8 writes no reset");

    for (int n = 0; n < 600; n++) begin
      bor_req  = ($urandom % 24) == 0;
      iop_req  = ($urandom % 24) == 0;
      cfg_req  = ($urandom % 24) == 0;
      wdt_req  = ($urandom % 24) == 0;
      swr_req  = ($urandom % 24) == 0;
      trap_req = ($urandom % 24) == 0;
      if (($urandom % 6) == 0) mclr_pin_n = ~mclr_pin_n;
      wr_en    = ($urandom % 6) == 0;
      wr_data  = 16'($urandom);
      tick();
    end
    {bor_req, iop_req, cfg_req, wdt_req, swr_req, trap_req, wr_en} = '0;
    mclr_pin_n = 1'b1;
    repeat (STR + 2) tick();

    wr_en = 1'b1; wr_data = 16'hFFFF; tick(); wr_en = 1'b0;
    por_req = 1'b1; bor_req = 1'b1; repeat (2) tick();
    chk(status, 16'h0001, "R5 power-on clears others");
    por_req = 1'b0; tick();
    bor_req = 1'b0; tick();
    chk(status, 16'h0003, "R10 brown-out with power-on");
    repeat (STR + 2) tick();
    finish_run();
  end
endmodule